// File: doc/BRIEF.md
# Multi-Mode 16-bit Timer/Counter

This block is a 16-bit up/down counter with a shared capture/reload register. It is exposed as byte-wide registers and controlled by a single control byte. The count source is either a machine-cycle tick, or falling edges of an external event pin sampled once per machine cycle. The run bit, two clock-select bits and a capture/reload select bit together pick one of three behaviours, and the same counter serves all of them.

In capture mode the counter free-runs, and a falling edge on the trigger pin copies the count into the capture register. In auto-reload mode an overflow reloads the count from the reload register. A trigger edge can also force a reload. When the direction option is on, the trigger pin level picks up or down counting instead. In baud-rate mode the counter advances on a half-oscillator-rate tick and reloads on every overflow. Each overflow gives a one-cycle baud pulse and does not touch the overflow flag.

Software reaches the control byte, a direction-option byte, the two count bytes and the two capture/reload bytes through one address/data port with combinational read data.

Top module: `tmr16`

## Requirements
- R1: After reset every register reads 0x00, and ovf_flag, ext_flag and baud_pulse are low.
- R2: With the run bit (control bit 0) clear, the count holds and no flag is set by hardware.
- R3: With control bit 1 clear, a running counter advances by one on each mc_tick. With bit 1 set, it advances once per falling edge of ev_in, where the edge is seen between two successive mc_tick samples.
- R4: Mode decode: run=0 is off. Run=1 with control bit 4 or bit 5 set is baud-rate mode. Otherwise control bit 2 set is capture mode and clear is auto-reload mode.
- R5: In auto-reload mode, counting up, a tick at 0xFFFF loads the count from the capture/reload register and sets the overflow flag (control bit 6, also ovf_flag).
- R6: In capture mode, with trigger enable (control bit 3) set, a falling trig_in edge sampled on mc_tick copies the current count into the capture/reload register and sets the external flag (control bit 7, also ext_flag). The count keeps advancing. A tick at 0xFFFF wraps the count to 0x0000 and sets the overflow flag.
- R7: In auto-reload mode, with the direction option off and trigger enable set, a falling trig_in edge loads the count from the reload register and sets the external flag. This load takes priority over a tick in the same cycle.
- R8: With the direction option (address 1, bit 0) set in auto-reload mode, trig_in low counts down and trig_in high counts up. Counting down, a tick when the count equals the reload value loads 0xFFFF and sets the overflow flag. Trigger edges then neither reload nor set the external flag.
- R9: In baud-rate mode the counter advances on half_tick and ignores mc_tick. A tick at 0xFFFF loads the reload value and drives baud_pulse high for exactly one clock. The overflow flag is not set.
- R10: Register map: 0 control, 1 direction option, 2/3 count low/high, 4/5 capture/reload low/high, and other addresses read 0x00. Writing the control byte writes both flags, so 0 clears them. A hardware set in the same cycle wins.
- R11: A software write to a count byte in the same cycle as a tick wins, and that tick is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for read and write |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data at addr |
| mc_tick | input | 1 | Machine-cycle tick, one clock wide |
| half_tick | input | 1 | Half-oscillator-rate tick for baud mode |
| ev_in | input | 1 | External event count input |
| trig_in | input | 1 | External capture/reload trigger and direction input |
| ovf_flag | output | 1 | Overflow flag |
| ext_flag | output | 1 | External trigger flag |
| baud_pulse | output | 1 | One-clock pulse per baud-mode overflow |

## Verification
The bound checker watches several behaviours on every cycle. A stopped timer holds its count and flags. An up-count overflow in auto-reload mode lands on the reload value. A down-count match wraps to all ones. A capture edge stores the previous count, and baud pulses appear only in baud-rate mode with no overflow flag.

Other behaviours depend on sequences the bench has to build. These are event counting through sampled edges, the priority of a trigger reload over a tick, and trigger edges being ignored under the direction option. They also include the write-wins rule for the count and the exact pulse rate on the baud output.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

   typedef enum logic [1:0] {
      MODE_OFF     = 2'd0,
      MODE_RELOAD  = 2'd1,
      MODE_CAPTURE = 2'd2,
      MODE_BAUD    = 2'd3
   } tmr_mode_e;

   // control byte fields
   localparam int CB_RUN    = 0;
   localparam int CB_EVSEL  = 1;
   localparam int CB_CAPSEL = 2;
   localparam int CB_TRIGEN = 3;
   localparam int CB_RXCLK  = 4;
   localparam int CB_TXCLK  = 5;
   localparam int CB_OVF    = 6;
   localparam int CB_EXT    = 7;

   // direction-option byte field
   localparam int DB_DOWN = 0;

   // register addresses
   localparam int A_CTRL = 0;
   localparam int A_DIR  = 1;
   localparam int A_CNT0 = 2;

   function automatic tmr_mode_e decode_mode(input logic run, input logic rx,
                                             input logic tx, input logic cap);
      if (!run)          return MODE_OFF;
      else if (rx || tx) return MODE_BAUD;
      else if (cap)      return MODE_CAPTURE;
      else               return MODE_RELOAD;
   endfunction

endpackage

// File: rtl/tmr16_fall.sv
module tmr16_fall (
   input  logic clk,
   input  logic rst_n,
   input  logic sample,
   input  logic din,
   output logic fall
);
   logic prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n)      prev_q <= 1'b0;
      else if (sample) prev_q <= din;
   end

   assign fall = sample && prev_q && !din;
endmodule

// File: rtl/tmr16_ctrl.sv
module tmr16_ctrl
   import tmr16_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BYTE_W-1:0] wdata,
   input  logic              ovf_set,
   input  logic              ext_set,
   output logic [BYTE_W-1:0] ctrl_q,
   output logic [BYTE_W-1:0] dir_q
);
   localparam logic [ADDR_W-1:0] ADR_CTRL = ADDR_W'(A_CTRL);
   localparam logic [ADDR_W-1:0] ADR_DIR  = ADDR_W'(A_DIR);

   logic [BYTE_W-1:0] ctrl_n;

   always_comb begin
      ctrl_n = ctrl_q;
      if (wr_en && addr == ADR_CTRL) ctrl_n = wdata;
      if (ovf_set) ctrl_n[CB_OVF] = 1'b1;
      if (ext_set) ctrl_n[CB_EXT] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         dir_q  <= '0;
      end else begin
         ctrl_q <= ctrl_n;
         if (wr_en && addr == ADR_DIR) dir_q <= wdata;
      end
   end
endmodule

// File: rtl/tmr16_count.sv
module tmr16_count
   import tmr16_pkg::*;
#(
   parameter int BYTE_W    = 8,
   parameter int NUM_BYTES = 2,
   parameter int ADDR_W    = 3,
   localparam int CNT_W    = BYTE_W * NUM_BYTES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  tmr_mode_e         mode,
   input  logic              dcen,
   input  logic              trig_up,
   input  logic              tick,
   input  logic              trig_evt,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BYTE_W-1:0] wdata,
   output logic [CNT_W-1:0]  cnt_q,
   output logic [CNT_W-1:0]  rc_q,
   output logic              ovf_set,
   output logic              ext_set,
   output logic              baud_pulse
);
   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
   localparam logic [CNT_W-1:0] ALL1 = '1;

   logic [CNT_W-1:0] cnt_n, rc_n;
   logic             pulse_n, cap_evt;

   always_comb begin
      cnt_n   = cnt_q;
      rc_n    = rc_q;
      ovf_set = 1'b0;
      ext_set = 1'b0;
      pulse_n = 1'b0;
      cap_evt = 1'b0;
      unique case (mode)
         MODE_RELOAD: begin
            if (!dcen && trig_evt) begin
               cnt_n   = rc_q;
               ext_set = 1'b1;
            end else if (tick) begin
               if (dcen && !trig_up) begin
                  if (cnt_q == rc_q) begin
                     cnt_n   = ALL1;
                     ovf_set = 1'b1;
                  end else begin
                     cnt_n = cnt_q - ONE;
                  end
               end else if (cnt_q == ALL1) begin
                  cnt_n   = rc_q;
                  ovf_set = 1'b1;
               end else begin
                  cnt_n = cnt_q + ONE;
               end
            end
         end
         MODE_CAPTURE: begin
            if (tick) begin
               cnt_n   = cnt_q + ONE;
               ovf_set = (cnt_q == ALL1);
            end
            if (trig_evt) begin
               rc_n    = cnt_q;
               ext_set = 1'b1;
               cap_evt = 1'b1;
            end
         end
         MODE_BAUD: begin
            if (tick) begin
               if (cnt_q == ALL1) begin
                  cnt_n   = rc_q;
                  pulse_n = 1'b1;
               end else begin
                  cnt_n = cnt_q + ONE;
               end
            end
            if (trig_evt) ext_set = 1'b1;
         end
         default: ;
      endcase
      // software byte writes: count write beats a tick, capture beats a write
      for (int i = 0; i < NUM_BYTES; i++) begin
         if (wr_en && addr == ADDR_W'(A_CNT0 + i))
            cnt_n[i*BYTE_W +: BYTE_W] = wdata;
         if (wr_en && !cap_evt && addr == ADDR_W'(A_CNT0 + NUM_BYTES + i))
            rc_n[i*BYTE_W +: BYTE_W] = wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q      <= '0;
         rc_q       <= '0;
         baud_pulse <= 1'b0;
      end else begin
         cnt_q      <= cnt_n;
         rc_q       <= rc_n;
         baud_pulse <= pulse_n;
      end
   end
endmodule

// File: rtl/tmr16.sv
module tmr16
   import tmr16_pkg::*;
#(
   parameter int BYTE_W    = 8,
   parameter int NUM_BYTES = 2,
   parameter int ADDR_W    = 3,
   localparam int CNT_W    = BYTE_W * NUM_BYTES,
   localparam int NUM_REGS = A_CNT0 + 2 * NUM_BYTES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BYTE_W-1:0] wdata,
   output logic [BYTE_W-1:0] rdata,
   input  logic              mc_tick,
   input  logic              half_tick,
   input  logic              ev_in,
   input  logic              trig_in,
   output logic              ovf_flag,
   output logic              ext_flag,
   output logic              baud_pulse
);
   generate
      if (BYTE_W < 8) begin : g_bad_byte
         $error("tmr16: BYTE_W must hold the 8 control bits");
      end
      if ((1 << ADDR_W) < NUM_REGS) begin : g_bad_addr
         $error("tmr16: ADDR_W too narrow for the register map");
      end
      if (NUM_BYTES < 1) begin : g_bad_lanes
         $error("tmr16: NUM_BYTES must be at least 1");
      end
   endgenerate

   localparam int NUM_PINS = 2;   // index 0: event input, 1: trigger input

   logic [BYTE_W-1:0]   ctrl_q, dir_q;
   logic [CNT_W-1:0]    cnt_q, rc_q;
   logic [NUM_PINS-1:0] pin_raw, pin_fall;
   logic                ovf_set, ext_set;
   logic                tick, trig_evt, trig_rl, dcen;
   tmr_mode_e           mode;

   assign pin_raw = {trig_in, ev_in};

   generate
      for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
         tmr16_fall u_fall (
            .clk   (clk),
            .rst_n (rst_n),
            .sample(mc_tick),
            .din   (pin_raw[p]),
            .fall  (pin_fall[p])
         );
      end
   endgenerate

   assign mode = decode_mode(ctrl_q[CB_RUN], ctrl_q[CB_RXCLK],
                             ctrl_q[CB_TXCLK], ctrl_q[CB_CAPSEL]);
   assign dcen     = dir_q[DB_DOWN];
   assign trig_evt = ctrl_q[CB_TRIGEN] && pin_fall[1];
   assign trig_rl  = trig_evt && (mode == MODE_RELOAD) && !dcen;

   always_comb begin
      unique case (mode)
         MODE_BAUD:                 tick = half_tick;
         MODE_RELOAD, MODE_CAPTURE: tick = ctrl_q[CB_EVSEL] ? pin_fall[0] : mc_tick;
         default:                   tick = 1'b0;
      endcase
   end

   tmr16_ctrl #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .addr   (addr),
      .wdata  (wdata),
      .ovf_set(ovf_set),
      .ext_set(ext_set),
      .ctrl_q (ctrl_q),
      .dir_q  (dir_q)
   );

   tmr16_count #(.BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES), .ADDR_W(ADDR_W)) u_count (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode      (mode),
      .dcen      (dcen),
      .trig_up   (trig_in),
      .tick      (tick),
      .trig_evt  (trig_evt),
      .wr_en     (wr_en),
      .addr      (addr),
      .wdata     (wdata),
      .cnt_q     (cnt_q),
      .rc_q      (rc_q),
      .ovf_set   (ovf_set),
      .ext_set   (ext_set),
      .baud_pulse(baud_pulse)
   );

   always_comb begin
      rdata = '0;
      if (addr == ADDR_W'(A_CTRL)) rdata = ctrl_q;
      if (addr == ADDR_W'(A_DIR))  rdata = dir_q;
      for (int i = 0; i < NUM_BYTES; i++) begin
         if (addr == ADDR_W'(A_CNT0 + i))             rdata = cnt_q[i*BYTE_W +: BYTE_W];
         if (addr == ADDR_W'(A_CNT0 + NUM_BYTES + i)) rdata = rc_q[i*BYTE_W +: BYTE_W];
      end
   end

   assign ovf_flag = ctrl_q[CB_OVF];
   assign ext_flag = ctrl_q[CB_EXT];
endmodule

// File: rtl/tmr16_chk.sv
module tmr16_chk
   import tmr16_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input tmr_mode_e        mode,
   input logic             dcen,
   input logic             trig_in,
   input logic             tick,
   input logic             trig_evt,
   input logic             trig_rl,
   input logic [CNT_W-1:0] cnt_q,
   input logic [CNT_W-1:0] rc_q,
   input logic             ovf_flag,
   input logic             ext_flag,
   input logic             baud_pulse
);
   localparam logic [CNT_W-1:0] ALL1 = '1;

   assert_off_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_OFF && !wr_en) |=> ($stable(cnt_q) && $stable(ovf_flag) && $stable(ext_flag)));

   assert_up_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_RELOAD && !dcen && tick && !trig_rl && !wr_en && cnt_q == ALL1)
      |=> (cnt_q == $past(rc_q) && ovf_flag));

   assert_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_CAPTURE && trig_evt && !wr_en) |=> (rc_q == $past(cnt_q) && ext_flag));

   assert_down_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_RELOAD && dcen && !trig_in && tick && !wr_en && cnt_q == rc_q)
      |=> (cnt_q == ALL1 && ovf_flag));

   assert_baud_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
      baud_pulse |-> $past(mode == MODE_BAUD));

   assert_baud_no_ovf_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_BAUD && !wr_en) |=> !$rose(ovf_flag));
endmodule

bind tmr16 tmr16_chk #(.CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .mode      (mode),
   .dcen      (dcen),
   .trig_in   (trig_in),
   .tick      (tick),
   .trig_evt  (trig_evt),
   .trig_rl   (trig_rl),
   .cnt_q     (cnt_q),
   .rc_q      (rc_q),
   .ovf_flag  (ovf_flag),
   .ext_flag  (ext_flag),
   .baud_pulse(baud_pulse)
);

// File: tb/tmr16_bench.sv
module tmr16_bench;
   localparam int CLK_PERIOD = 10;

   typedef struct {
      int         kind;   // 0 rdata, 1 ovf_flag, 2 ext_flag, 3 baud_pulse
      logic [7:0] exp;
      string      tag;
   } item_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       mc_tick = 1'b0, half_tick = 1'b0, ev_in = 1'b0, trig_in = 1'b0;
   logic       ovf_flag, ext_flag, baud_pulse;

   int n_cmp = 0, n_bad = 0, n_pulse = 0;
   item_t sb_q[$];
   event  ev_chk;

   always #(CLK_PERIOD/2) clk = ~clk;

   tmr16 u_tmr16 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .mc_tick(mc_tick), .half_tick(half_tick), .ev_in(ev_in),
      .trig_in(trig_in), .ovf_flag(ovf_flag), .ext_flag(ext_flag),
      .baud_pulse(baud_pulse)
   );

   always @(negedge clk) if (rst_n && baud_pulse) n_pulse++;

   // monitor: pops an expected item and compares against the design
   initial begin
      forever begin
         @(ev_chk);
         #1;
         while (sb_q.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it = sb_q.pop_front();
            case (it.kind)
               0:       act = rdata;
               1:       act = {7'd0, ovf_flag};
               2:       act = {7'd0, ext_flag};
               default: act = {7'd0, baud_pulse};
            endcase
            n_cmp++;
            if (act !== it.exp) begin
               n_bad++;
               $display("FAIL %s: actual %02h expected %02h", it.tag, act, it.exp);
            end
         end
      end
   end

   task automatic push(input int kind, input logic [2:0] a, input logic [7:0] e, input string tag);
      item_t it;
      addr = a;
      it.kind = kind; it.exp = e; it.tag = tag;
      sb_q.push_back(it);
      ->ev_chk;
      #2;
   endtask

   task automatic chk_reg(input logic [2:0] a, input logic [7:0] e, input string tag);
      push(0, a, e, tag);
   endtask

   task automatic chk_out(input int kind, input logic e, input string tag);
      push(kind, 3'd0, {7'd0, e}, tag);
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic mc(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); mc_tick = 1'b1;
         @(negedge clk); mc_tick = 1'b0;
      end
   endtask

   task automatic hb(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); half_tick = 1'b1;
         @(negedge clk); half_tick = 1'b0;
      end
   endtask

   task automatic summary;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      for (int a = 0; a < 8; a++) chk_reg(3'(a), 8'h00, "R1 reset register");
      chk_out(1, 1'b0, "R1 reset ovf_flag");
      chk_out(2, 1'b0, "R1 reset ext_flag");
      chk_out(3, 1'b0, "R1 reset baud_pulse");

      // R5 auto-reload up overflow
      wr(2, 8'hFD); wr(3, 8'hFF); wr(4, 8'h34); wr(5, 8'h12); wr(0, 8'h01);
      mc(2);
      chk_reg(2, 8'hFF, "R3 timer tick lo");
      chk_reg(3, 8'hFF, "R3 timer tick hi");
      chk_out(1, 1'b0, "R5 no ovf before wrap");
      mc(1);
      chk_reg(2, 8'h34, "R5 reload lo");
      chk_reg(3, 8'h12, "R5 reload hi");
      chk_out(1, 1'b1, "R5 ovf_flag");
      chk_reg(0, 8'h41, "R5 ctrl flag bit");
      wr(0, 8'h01);
      chk_out(1, 1'b0, "R10 flag cleared by write");

      // R11 write wins over same-cycle tick
      @(negedge clk); mc_tick = 1'b1; wr_en = 1'b1; addr = 3'd2; wdata = 8'h80;
      @(negedge clk); mc_tick = 1'b0; wr_en = 1'b0;
      chk_reg(2, 8'h80, "R11 write wins lo");
      chk_reg(3, 8'h12, "R11 write wins hi");

      // R2 off holds
      wr(0, 8'h00);
      mc(3);
      chk_reg(2, 8'h80, "R2 off hold");
      chk_out(1, 1'b0, "R2 off no ovf");

      // R3 event counting
      wr(2, 8'h10); wr(3, 8'h00); wr(0, 8'h03);
      ev_in = 1'b1; mc(1);
      ev_in = 1'b0; mc(1);
      chk_reg(2, 8'h11, "R3 event edge");
      mc(2);
      chk_reg(2, 8'h11, "R3 no edge no count");
      ev_in = 1'b1; mc(1); ev_in = 1'b0; mc(1);
      chk_reg(2, 8'h12, "R3 second edge");

      // R6 capture
      wr(0, 8'h00); wr(2, 8'hFE); wr(3, 8'h00);
      trig_in = 1'b1; wr(0, 8'h0D);
      mc(1);
      trig_in = 1'b0; mc(1);
      chk_reg(4, 8'hFF, "R6 capture lo");
      chk_reg(5, 8'h00, "R6 capture hi");
      chk_reg(2, 8'h00, "R6 count continues lo");
      chk_reg(3, 8'h01, "R6 count continues hi");
      chk_out(2, 1'b1, "R6 ext_flag");
      chk_reg(0, 8'h8D, "R6 ctrl ext bit");
      chk_reg(1, 8'h00, "R10 direction byte");
      wr(2, 8'hFF); wr(3, 8'hFF);
      mc(1);
      chk_reg(2, 8'h00, "R6 wrap lo");
      chk_reg(3, 8'h00, "R6 wrap hi");
      chk_out(1, 1'b1, "R6 wrap ovf");

      // R7 trigger reload
      wr(0, 8'h00); wr(2, 8'h00); wr(3, 8'h50); wr(4, 8'h34); wr(5, 8'h12);
      trig_in = 1'b1; wr(0, 8'h09);
      mc(1);
      chk_reg(2, 8'h01, "R7 counting before trigger");
      trig_in = 1'b0; mc(1);
      chk_reg(2, 8'h34, "R7 trigger reload lo");
      chk_reg(3, 8'h12, "R7 trigger reload hi");
      chk_out(2, 1'b1, "R7 ext_flag");
      chk_out(1, 1'b0, "R7 no ovf");

      // R8 down counting
      wr(0, 8'h00); wr(1, 8'h01);
      wr(2, 8'h02); wr(3, 8'h01); wr(4, 8'h00); wr(5, 8'h01);
      wr(0, 8'h09);
      mc(2);
      chk_reg(2, 8'h00, "R8 down lo");
      chk_reg(3, 8'h01, "R8 down hi");
      chk_out(1, 1'b0, "R8 no ovf yet");
      mc(1);
      chk_reg(2, 8'hFF, "R8 wrap lo");
      chk_reg(3, 8'hFF, "R8 wrap hi");
      chk_out(1, 1'b1, "R8 wrap ovf");
      wr(0, 8'h09);
      trig_in = 1'b1; mc(1);
      chk_reg(3, 8'h01, "R8 up direction reload");
      trig_in = 1'b0; mc(1);
      chk_reg(3, 8'hFF, "R8 trigger edge ignored");
      chk_out(2, 1'b0, "R8 no ext_flag");
      wr(1, 8'h00);

      // R9 baud generation
      wr(0, 8'h00); wr(2, 8'hFE); wr(3, 8'hFF); wr(4, 8'hFE); wr(5, 8'hFF);
      wr(0, 8'h11);
      hb(1);
      chk_reg(2, 8'hFF, "R9 half tick count");
      chk_out(3, 1'b0, "R9 no pulse before wrap");
      hb(1);
      chk_out(3, 1'b1, "R9 baud pulse");
      chk_reg(2, 8'hFE, "R9 baud reload");
      @(negedge clk);
      chk_out(3, 1'b0, "R9 pulse one clock");
      n_pulse = 0;
      hb(8);
      @(negedge clk);
      push(0, 3'd0, 8'h11, "R9 ovf not set in baud");
      begin
         item_t it;
         it.kind = 0; it.exp = 8'd4; it.tag = "R9 pulse count";
         n_cmp++;
         if (n_pulse != 4) begin
            n_bad++;
            $display("FAIL R9 pulse count: actual %0d expected 4", n_pulse);
         end
      end
      mc(3);
      chk_reg(2, 8'hFE, "R9 mc_tick ignored");

      // R4 decode variants
      wr(0, 8'h21);
      hb(1);
      chk_reg(2, 8'hFF, "R4 tx select is baud");
      wr(0, 8'h10);
      hb(2);
      chk_reg(2, 8'hFF, "R4 run clear is off");
      chk_reg(7, 8'h00, "R10 unused address");

      summary();
   end
endmodule